// File: doc/BRIEF.md
# Dual Staircase Sine Tone Synthesizer

This block produces the two sine components of a dual-tone keypad signal from a 3.579545 MHz reference, delivered as a clock enable. A low-group (row) channel and a high-group (column) channel each pair a programmable integer divider with a step counter. The step counter walks a sine table and yields an 8-bit offset-binary code for a resistor-ladder DAC. Row tones use 16 steps per cycle and column tones use 32. Each channel takes its own enable and a 2-bit index from the upstream key decoder. The block also outputs a saturated digital mix in which the row code is scaled by 4/5, so the column tone comes out about 2 dB louder.

Each channel is a two-state machine. The states are `CH_HOLD` and `CH_RUN`. The START transition goes from `CH_HOLD` to `CH_RUN` when the enable is high, and it latches the divisor chosen by the index. The STOP transition goes from `CH_RUN` to `CH_HOLD` when the enable is low. In `CH_HOLD` the divider and the step counter are cleared, so the code sits at the zero-crossing value. In `CH_RUN` each reference pulse advances the divider. When the divider wraps, the step counter advances.

The divisors give these frequencies:

| Group | Index | Divisor | Steps | Frequency |
|---|---|---|---|---|
| Row | 0 | 319 | 16 | 701.3 Hz |
| Row | 1 | 290 | 16 | 771.4 Hz |
| Row | 2 | 261 | 16 | 857.2 Hz |
| Row | 3 | 239 | 16 | 936.1 Hz |
| Column | 0 | 92 | 32 | 1215.9 Hz |
| Column | 1 | 84 | 32 | 1331.7 Hz |
| Column | 2 | 76 | 32 | 1471.9 Hz |
| Column | 3 | 68 | 32 | 1645.0 Hz |

All eight lie within 0.75% of the nominal keypad frequencies.

Top module: `dual_tone_synth`

## Requirements
- R1: After reset both codes equal 128 and the mix output equals 230.
- R2: With the high channel running, index 0, 1, 2, 3 selects a step period of 92, 84, 76, 68 reference pulses, and one output cycle is 32 steps (divisor × 32 pulses between successive rises of the code out of 128).
- R3: With the low channel running, index 0, 1, 2, 3 selects a step period of 319, 290, 261, 239 reference pulses, and one output cycle is 16 steps (divisor × 16 pulses per cycle).
- R4: At step s of an N-step cycle the code equals 128 + round(127·sin(2πs/N)), an 8-bit offset-binary value.
- R5: While a channel's enable is low, its code is 128 from the second clock edge after the enable falls.
- R6: A channel always starts at phase zero when enabled. The code stays 128 for exactly one divisor's worth of reference pulses, counted from the clock edge that follows the one which samples the enable high, and then steps up.
- R7: The index is captured when the channel starts. Index changes while the channel stays enabled have no effect on the output period.
- R8: Divider and step state advance only on clock edges where the reference enable is high, so periods measured in reference pulses do not depend on the reference duty.
- R9: The mix output equals min(floor(4·low_code/5) + high_code, 511).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference enable, one pulse per 3.579545 MHz period |
| low_en | input | 1 | Run the low-group (row) channel |
| low_sel | input | 2 | Low-group frequency index |
| high_en | input | 1 | Run the high-group (column) channel |
| high_sel | input | 2 | High-group frequency index |
| low_code | output | 8 | Low-group DAC code, offset binary |
| high_code | output | 8 | High-group DAC code, offset binary |
| mix_out | output | 9 | Weighted sum of both codes, saturated |

## Verification
The bench builds the block with its default parameters: row divisors 319/290/261/239 over 16 steps, column divisors 92/84/76/68 over 32 steps, and 8-bit codes. With these values a full period of every one of the eight tones takes at most about 5,100 reference pulses, so every period can be counted exactly in pulses. The same parameters also let every table step be compared with a reference-computed sine at each clock. One run drives the reference enable at one pulse in three clocks with both channels active, which shows that periods follow the reference pulses rather than the clock. Another run changes the index mid-tone.

// File: rtl/tone_synth_pkg.sv
package tone_synth_pkg;

    localparam int unsigned CODE_W   = 8;
    localparam int unsigned FINE_LOG = 5;                 // finest table: 32 steps
    localparam logic [CODE_W-1:0] MID_CODE = 8'd128;

    typedef enum logic {
        CH_HOLD,
        CH_RUN
    } chan_state_e;

    // Quarter-wave amplitude, round(127*sin(k*pi/16)), k = 0..8
    function automatic logic [6:0] quarter_sine(input logic [3:0] k);
        logic [6:0] a;
        unique case (k)
            4'd0:    a = 7'd0;
            4'd1:    a = 7'd25;
            4'd2:    a = 7'd49;
            4'd3:    a = 7'd71;
            4'd4:    a = 7'd90;
            4'd5:    a = 7'd106;
            4'd6:    a = 7'd117;
            4'd7:    a = 7'd125;
            default: a = 7'd127;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/sine_rom.sv
module sine_rom
    import tone_synth_pkg::*;
#(
    parameter int unsigned LOG2_STEPS = 5
) (
    input  logic [LOG2_STEPS-1:0] step,
    output logic [CODE_W-1:0]     code
);

    localparam int unsigned PAD_W = FINE_LOG - LOG2_STEPS;

    logic [FINE_LOG-1:0] fine_ph;
    logic [3:0]          qidx;
    logic [6:0]          amp;

    // Map a coarse table onto the 32-step phase grid
    generate
        if (PAD_W == 0) begin : g_native
            assign fine_ph = step;
        end else begin : g_spread
            assign fine_ph = {step, {PAD_W{1'b0}}};
        end
    endgenerate

    always_comb begin
        qidx = {1'b0, fine_ph[2:0]};
        if (fine_ph[3]) begin
            qidx = 4'd8 - qidx;
        end
        amp = quarter_sine(qidx);
        if (fine_ph[4]) begin
            code = MID_CODE - {1'b0, amp};
        end else begin
            code = MID_CODE + {1'b0, amp};
        end
    end

endmodule

// File: rtl/tone_chan.sv
module tone_chan
    import tone_synth_pkg::*;
#(
    parameter int unsigned LOG2_STEPS = 5,
    parameter int unsigned DIV_W      = 7,
    parameter int unsigned DIV0       = 92,
    parameter int unsigned DIV1       = 84,
    parameter int unsigned DIV2       = 76,
    parameter int unsigned DIV3       = 68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              en,
    input  logic [1:0]        idx,
    output logic [CODE_W-1:0] code
);

    chan_state_e           state_q, state_d;
    logic [LOG2_STEPS-1:0] step_q, step_d;
    logic [DIV_W-1:0]      div_q, div_d;
    logic [DIV_W-1:0]      lim_q, lim_d;
    logic [DIV_W-1:0]      lim_pick;

    always_comb begin
        unique case (idx)
            2'd0:    lim_pick = DIV_W'(DIV0);
            2'd1:    lim_pick = DIV_W'(DIV1);
            2'd2:    lim_pick = DIV_W'(DIV2);
            default: lim_pick = DIV_W'(DIV3);
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_HOLD;
            step_q  <= '0;
            div_q   <= '0;
            lim_q   <= DIV_W'(DIV0);
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            div_q   <= div_d;
            lim_q   <= lim_d;
        end
    end

    // transitions: START (HOLD->RUN), STOP (RUN->HOLD)
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        div_d   = div_q;
        lim_d   = lim_q;
        unique case (state_q)
            CH_HOLD: begin
                step_d = '0;
                div_d  = '0;
                if (en) begin
                    state_d = CH_RUN;
                    lim_d   = lim_pick;
                end
            end
            CH_RUN: begin
                if (!en) begin
                    state_d = CH_HOLD;
                    step_d  = '0;
                    div_d   = '0;
                end else if (ref_en) begin
                    if (div_q == lim_q - 1'b1) begin
                        div_d  = '0;
                        step_d = step_q + 1'b1;
                    end else begin
                        div_d = div_q + 1'b1;
                    end
                end
            end
            default: state_d = CH_HOLD;
        endcase
    end

    // output
    sine_rom #(.LOG2_STEPS(LOG2_STEPS)) u_rom (
        .step (step_q),
        .code (code)
    );

    // R5
    hold_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == CH_HOLD |-> code == MID_CODE);

    // R8
    step_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && en && !ref_en) |=> $stable(step_q));

    // R6
    start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HOLD && en) |=> (step_q == '0 && div_q == '0));

    // R7
    lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && en) |=> $stable(lim_q));

    // R2
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_q < lim_q);

endmodule

// File: rtl/tone_mixer.sv
module tone_mixer
    import tone_synth_pkg::*;
#(
    parameter int unsigned MIX_W = CODE_W + 1
) (
    input  logic [CODE_W-1:0] low_code,
    input  logic [CODE_W-1:0] high_code,
    output logic [MIX_W-1:0]  mix
);

    localparam int unsigned SUM_W = CODE_W + 3;
    localparam logic [SUM_W-1:0] SAT_MAX = SUM_W'((1 << MIX_W) - 1);

    logic [SUM_W-1:0] low_x4;
    logic [SUM_W-1:0] low_scaled;
    logic [SUM_W-1:0] sum;

    always_comb begin
        low_x4     = {1'b0, low_code, 2'b00};
        low_scaled = low_x4 / SUM_W'(5);
        sum        = low_scaled + SUM_W'(high_code);
        if (sum > SAT_MAX) begin
            mix = SAT_MAX[MIX_W-1:0];
        end else begin
            mix = sum[MIX_W-1:0];
        end
    end

endmodule

// File: rtl/dual_tone_synth.sv
module dual_tone_synth
    import tone_synth_pkg::*;
#(
    parameter int unsigned LOW_LOG2_STEPS  = 4,
    parameter int unsigned HIGH_LOG2_STEPS = 5,
    parameter int unsigned LOW_DIV_W       = 9,
    parameter int unsigned HIGH_DIV_W      = 7,
    parameter int unsigned LOW_DIV0        = 319,
    parameter int unsigned LOW_DIV1        = 290,
    parameter int unsigned LOW_DIV2        = 261,
    parameter int unsigned LOW_DIV3        = 239,
    parameter int unsigned HIGH_DIV0       = 92,
    parameter int unsigned HIGH_DIV1       = 84,
    parameter int unsigned HIGH_DIV2       = 76,
    parameter int unsigned HIGH_DIV3       = 68
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       low_en,
    input  logic [1:0] low_sel,
    input  logic       high_en,
    input  logic [1:0] high_sel,
    output logic [7:0] low_code,
    output logic [7:0] high_code,
    output logic [8:0] mix_out
);

    tone_chan #(
        .LOG2_STEPS (LOW_LOG2_STEPS),
        .DIV_W      (LOW_DIV_W),
        .DIV0       (LOW_DIV0),
        .DIV1       (LOW_DIV1),
        .DIV2       (LOW_DIV2),
        .DIV3       (LOW_DIV3)
    ) u_low (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_en (ref_tick),
        .en     (low_en),
        .idx    (low_sel),
        .code   (low_code)
    );

    tone_chan #(
        .LOG2_STEPS (HIGH_LOG2_STEPS),
        .DIV_W      (HIGH_DIV_W),
        .DIV0       (HIGH_DIV0),
        .DIV1       (HIGH_DIV1),
        .DIV2       (HIGH_DIV2),
        .DIV3       (HIGH_DIV3)
    ) u_high (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_en (ref_tick),
        .en     (high_en),
        .idx    (high_sel),
        .code   (high_code)
    );

    tone_mixer #(.MIX_W(CODE_W + 1)) u_mix (
        .low_code  (low_code),
        .high_code (high_code),
        .mix       (mix_out)
    );

    // R9
    mix_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mix_out >= {1'b0, high_code});

    // R1
    idle_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_code == MID_CODE && high_code == MID_CODE) |-> mix_out == 9'd230);

endmodule

// File: tb/dual_tone_synth_tb.sv
module dual_tone_synth_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       low_en = 1'b0;
    logic [1:0] low_sel = 2'd0;
    logic       high_en = 1'b0;
    logic [1:0] high_sel = 2'd0;
    logic [7:0] low_code;
    logic [7:0] high_code;
    logic [8:0] mix_out;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_tone_synth u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .low_en    (low_en),
        .low_sel   (low_sel),
        .high_en   (high_en),
        .high_sel  (high_sel),
        .low_code  (low_code),
        .high_code (high_code),
        .mix_out   (mix_out)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int ref_mode = 0;
    int ref_ph = 0;

    // scoreboard: expected pulse counts between code rises, per channel
    int low_q[$];
    int high_q[$];
    int cur_div[2];
    string tag[2];
    int pc[2];
    int cnt[2];
    int nrise[2];
    int prev_code[2];
    bit prev_en[2];

    function automatic int low_div(int i);
        case (i)
            0: return 319;
            1: return 290;
            2: return 261;
            default: return 239;
        endcase
    endfunction

    function automatic int high_div(int i);
        case (i)
            0: return 92;
            1: return 84;
            2: return 76;
            default: return 68;
        endcase
    endfunction

    function automatic int exp_code(int s, int n);
        real v;
        v = 127.0 * $sin(2.0 * 3.14159265358979 * s / n);
        if (v >= 0.0) return 128 + $rtoi(v + 0.5);
        return 128 + $rtoi(v - 0.5);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference enable pattern
    always @(posedge clk) begin
        if (ref_mode == 0) begin
            ref_tick <= 1'b1;
        end else begin
            ref_tick <= (ref_ph == 0);
            ref_ph   <= (ref_ph + 1) % 3;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int c = 0; c < 2; c++) begin
                int code;
                bit en;
                int n;
                int e;
                code = (c == 0) ? int'(low_code) : int'(high_code);
                en   = (c == 0) ? low_en : high_en;
                n    = (c == 0) ? 16 : 32;
                if (!en) begin
                    if (!prev_en[c]) check(code == 128, "R5", "idle code", code, 128);
                end else if (!prev_en[c]) begin
                    pc[c] = 0;
                    cnt[c] = 0;
                    nrise[c] = 0;
                end else begin
                    e = exp_code((pc[c] / cur_div[c]) % n, n);
                    check(code == e, "R4", "step code", code, e);
                    if (prev_code[c] == 128 && code > 128) begin
                        if (c == 0 && low_q.size() > 0) begin
                            e = low_q.pop_front();
                            check(cnt[c] == e, (nrise[c] == 0) ? "R6" : tag[c], "low pulses", cnt[c], e);
                        end else if (c == 1 && high_q.size() > 0) begin
                            e = high_q.pop_front();
                            check(cnt[c] == e, (nrise[c] == 0) ? "R6" : tag[c], "high pulses", cnt[c], e);
                        end
                        nrise[c]++;
                        cnt[c] = 0;
                    end
                    cnt[c] += int'(ref_tick);
                    pc[c]  += int'(ref_tick);
                end
                prev_en[c] = en;
                prev_code[c] = code;
            end
            begin
                int m;
                m = (int'(low_code) * 4) / 5 + int'(high_code);
                if (m > 511) m = 511;
                check(int'(mix_out) == m, "R9", "mix", int'(mix_out), m);
            end
        end
    end

    // driver
    task automatic run_tone(int c, int idx, int periods, bit chg, string t);
        int n;
        n = (c == 0) ? 16 : 32;
        @(posedge clk);
        tag[c] = t;
        cur_div[c] = (c == 0) ? low_div(idx) : high_div(idx);
        if (c == 0) begin
            low_sel <= 2'(idx);
            low_en  <= 1'b1;
            low_q.push_back(cur_div[c]);
            for (int p = 0; p < periods; p++) low_q.push_back(cur_div[c] * n);
        end else begin
            high_sel <= 2'(idx);
            high_en  <= 1'b1;
            high_q.push_back(cur_div[c]);
            for (int p = 0; p < periods; p++) high_q.push_back(cur_div[c] * n);
        end
        if (chg) begin
            repeat (500) @(posedge clk);
            if (c == 0) low_sel <= 2'(idx) ^ 2'b11;
            else high_sel <= 2'(idx) ^ 2'b11;
        end
        while (((c == 0) ? low_q.size() : high_q.size()) > 0) @(posedge clk);
        @(posedge clk);
        if (c == 0) low_en <= 1'b0;
        else high_en <= 1'b0;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        check(low_code == 8'd128, "R1", "reset low code", int'(low_code), 128);
        check(high_code == 8'd128, "R1", "reset high code", int'(high_code), 128);
        check(mix_out == 9'd230, "R1", "reset mix", int'(mix_out), 230);

        for (int i = 0; i < 4; i++) run_tone(1, i, 2, 1'b0, "R2");
        for (int i = 0; i < 4; i++) run_tone(0, i, 2, 1'b0, "R3");

        run_tone(1, 1, 1, 1'b1, "R7");
        run_tone(0, 2, 1, 1'b1, "R7");

        ref_mode = 1;
        fork
            run_tone(0, 3, 1, 1'b0, "R8");
            run_tone(1, 3, 1, 1'b0, "R8");
        join
        ref_mode = 0;

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 200000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule